// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a serial memory. The system clock oversamples the two open-drain bus lines. The block recognises start and stop conditions and takes in the device address byte. It acknowledges the bytes addressed to it and turns each bus transaction into accesses on a plain memory port. The only way it touches the data line is an enable that pulls the line low. Latching and timing the nonvolatile commit is left to a companion block. That block watches the write strobe this engine emits once per data byte.

The device address byte carries a fixed 1010 prefix, then three select/page bits, then a direction bit. The parameter `SEL_BITS` sets how many of the three bits (counted from the top) must equal the strapped `pin_sel` inputs. The rest of the three bits become the upper bits of the word address. One word address counter persists between transactions. Writes step it inside a page of `2**PAGE_W` bytes. Reads step it across the whole array and wrap to zero.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0), `mem_we` is 0 and the word address counter is 0.
- R2: A device byte is acknowledged only if bits 7:4 are 1010 and the top `SEL_BITS` bits of bits 3:1 equal `pin_sel[2]` downward. Otherwise the engine acknowledges nothing and writes nothing until the next start.
- R3: A start in any state abandons the current transaction without a memory write and begins a new device byte. A stop always returns the engine to idle.
- R4: A write transaction is device byte (bit 0 = 0), then word address byte, then data. Each byte is acknowledged by a low data line in the ninth clock. Each data byte gives one single-cycle `mem_we` at address {page bits, word byte}.
- R5: During a write the low `PAGE_W` address bits step after every data byte and the upper bits are held. More than `2**PAGE_W` data bytes wrap inside the page and overwrite earlier ones.
- R6: A read (bit 0 = 1) returns the byte at the counter, which holds the last accessed address plus one. The page bits of a read device byte are ignored.
- R7: A write transaction stopped after its word address byte (by a repeated start) loads the counter and writes nothing. A read that follows returns the byte at the loaded address.
- R8: In a read, a master acknowledge makes the engine send the byte at the next address. The address wraps from the last array address to 0.
- R9: A master non-acknowledge ends the read: the engine releases the line and drives nothing until the next start.
- R10: Bytes go out most significant bit first, and the engine changes its line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| pin_sel | input | 3 | Strapped select value compared with the device byte |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_addr | output | ADDR_W | Memory port address |
| mem_we | output | 1 | One-cycle write strobe per received data byte |
| mem_wdata | output | 8 | Data for the write strobe |
| mem_rdata | input | 8 | Read data for `mem_addr`, valid one clock after the address |

## Verification
The hardest conditions to reach from the ports are the two wraps: a page write longer than a page, and a sequential read that crosses the top of the array. The bench reaches them by first placing the counter a few bytes short of each boundary with a dummy write. It then clocks enough bytes to pass the boundary, which puts the overwrite and the wrap to zero in the middle of one transaction. A start injected halfway through a data byte, and a device byte with a wrong select bit, reach the abort and mismatch paths.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } twi_state_t;

  // Fixed prefix plus the compared select bits, taken from bit 3 downward.
  function automatic logic dev_match(logic [7:0] b, logic [2:0] pins, int sel);
    if (b[7:4] != 4'b1010) return 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (i < sel && b[3-i] != pins[2-i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  // Uncompared select bits become the top of the word address.
  function automatic logic [10:0] word_addr(logic [7:0] dev, logic [7:0] wa, int sel);
    logic [2:0] pg;
    pg = dev[3:1] & (3'b111 >> sel);
    return {pg, wa};
  endfunction

  // Read step: wraps over the whole array of 2**aw bytes.
  function automatic logic [10:0] rd_step(logic [10:0] a, int aw);
    return (a + 11'd1) & 11'((1 << aw) - 1);
  endfunction

  // Write step: only the in-page bits advance.
  function automatic logic [10:0] wr_step(logic [10:0] a, int pw);
    logic [10:0] m;
    m = 11'((1 << pw) - 1);
    return (a & ~m) | ((a + 11'd1) & m);
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_fall,
  output logic sample_evt,
  output logic sample_bit
);
  logic scl_q, sda_q, rise_d;
  logic scl_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      rise_d <= 1'b0;
    end else begin
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      rise_d <= scl_rise;
    end
  end

  assign scl_rise   = scl_s & ~scl_q;
  assign scl_fall   = ~scl_s & scl_q;
  assign start_evt  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt   = scl_s & scl_q & ~sda_q & sda_s;
  // Bit taken one system clock after the synchronized rising edge.
  assign sample_evt = rise_d;
  assign sample_bit = sda_s;
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int SEL_BITS    = 1,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = 11 - SEL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        pin_sel,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  import twi_pkg::*;

  logic [1:0] raw_lines, sync_lines;
  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_lines[g]), .q_o(sync_lines[g])
    );
  end

  logic scl_s, sda_s;
  assign scl_s = sync_lines[1];
  assign sda_s = sync_lines[0];

  logic start_evt, stop_evt, scl_fall, sample_evt, sample_bit;

  twi_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt), .scl_fall(scl_fall),
    .sample_evt(sample_evt), .sample_bit(sample_bit)
  );

  twi_state_t        state;
  logic [3:0]        bit_cnt;
  logic [7:0]        rx_sh, tx_sh, wdata_q;
  logic [2:0]        dev_pg;
  logic [ADDR_W-1:0] addr_q, waddr_q;
  logic              rd_go, oe_q, we_q;

  // Named events for the checker.
  logic in_idle, in_dev, in_wdata, byte_done, ack_done;
  assign in_idle   = (state == ST_IDLE);
  assign in_dev    = (state == ST_DEV);
  assign in_wdata  = (state == ST_WDATA);
  assign byte_done = scl_fall && bit_cnt == 4'd8;
  assign ack_done  = scl_fall && bit_cnt == 4'd9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      wdata_q <= '0;
      dev_pg  <= '0;
      addr_q  <= '0;
      waddr_q <= '0;
      rd_go   <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_evt) begin
        state   <= ST_DEV;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else if (stop_evt) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        oe_q    <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sample_evt) begin
          if (bit_cnt < 4'd9) bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt < 4'd8) rx_sh <= {rx_sh[6:0], sample_bit};
          if (bit_cnt == 4'd8 && state == ST_RDATA && !oe_q) rd_go <= ~sample_bit;
        end else if (byte_done) begin
          unique case (state)
            ST_DEV: begin
              if (dev_match(rx_sh, pin_sel, SEL_BITS)) begin
                oe_q   <= 1'b1;
                dev_pg <= rx_sh[3:1];
                if (rx_sh[0]) begin
                  state <= ST_RDATA;
                  rd_go <= 1'b1;
                end else begin
                  state <= ST_WADDR;
                end
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_WADDR: begin
              oe_q   <= 1'b1;
              addr_q <= ADDR_W'(word_addr({4'b0, dev_pg, 1'b0}, rx_sh, SEL_BITS));
              state  <= ST_WDATA;
            end
            ST_WDATA: begin
              oe_q    <= 1'b1;
              we_q    <= 1'b1;
              waddr_q <= addr_q;
              wdata_q <= rx_sh;
              addr_q  <= ADDR_W'(wr_step(11'(addr_q), PAGE_W));
            end
            default: oe_q <= 1'b0;
          endcase
        end else if (ack_done) begin
          bit_cnt <= '0;
          if (state == ST_RDATA) begin
            if (rd_go) begin
              tx_sh  <= {mem_rdata[6:0], 1'b0};
              oe_q   <= ~mem_rdata[7];
              addr_q <= ADDR_W'(rd_step(11'(addr_q), ADDR_W));
            end else begin
              state <= ST_IDLE;
              oe_q  <= 1'b0;
            end
          end else begin
            oe_q <= 1'b0;
          end
        end else if (scl_fall && state == ST_RDATA && bit_cnt != 4'd0) begin
          oe_q  <= ~tx_sh[7];
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  assign sda_oe    = oe_q;
  assign mem_we    = we_q;
  assign mem_wdata = wdata_q;
  assign mem_addr  = we_q ? waddr_q : addr_q;

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] addr_q,
  input logic              in_idle,
  input logic              in_dev,
  input logic              in_wdata
);
  a_r3_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> in_dev);

  a_r3_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> in_idle);

  // R2 / R9: nothing driven while idle
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  a_r10_drive_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r4_we_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> in_wdata);

  a_r5_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> addr_q[ADDR_W-1:PAGE_W] == mem_addr[ADDR_W-1:PAGE_W]);
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
  .scl_s(scl_s), .sda_oe(sda_oe), .mem_we(mem_we), .mem_addr(mem_addr),
  .addr_q(addr_q), .in_idle(in_idle), .in_dev(in_dev), .in_wdata(in_wdata)
);

// File: tb/twi_mem_slave_test.sv
module twi_mem_slave_test;
  localparam int AW = 10;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_line;
  logic [2:0] pin_sel = 3'b101;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .pin_sel(pin_sel),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [1024];
  logic [7:0] exp_mem [1024];
  int we_count = 0;

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_count <= we_count + 1;
    end
    mem_rdata <= mem[mem_addr];
  end

  int checks = 0, errors = 0;
  logic done = 1'b0;

  task automatic check(string req, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  // R10: each bit read while the clock is high and required to hold across the high phase
  task automatic recv_byte(logic mack, output logic [7:0] b);
    logic v1, v2, steady;
    steady = 1'b1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      v1 = sda_line; tick(Q - 1);
      v2 = sda_line; tick(1);
      if (v1 != v2) steady = 1'b0;
      scl_m = 1'b0;
      b[i] = v1;
    end
    check("R10 line steady while clock high", int'(steady), 1);
    sda_m = ~mack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] devb(logic [AW-1:0] a, logic rw);
    return {4'b1010, 1'b1, a[9:8], rw};
  endfunction

  // Dummy write then repeated start read: leaves the bus after the device read byte
  task automatic point_at(logic [AW-1:0] a, string req);
    logic k;
    bus_start();
    send_byte(devb(a, 1'b0), k); check({req, " dev ack"}, int'(k), 1);
    send_byte(a[7:0], k);        check({req, " word ack"}, int'(k), 1);
    bus_start();
    send_byte(devb(a, 1'b1), k); check({req, " read dev ack"}, int'(k), 1);
  endtask

  // {addr, data}
  localparam logic [17:0] VEC [6] = '{18'h0053C, 18'h0FFA5, 18'h1005A,
                                      18'h2F081, 18'h3FF00, 18'h17FFF};

  initial begin
    logic k;
    logic [7:0] rb;
    int base_we;
    for (int i = 0; i < 1024; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    tick(5);
    check("R1 sda_oe at reset", int'(sda_oe), 0);
    check("R1 mem_we at reset", int'(mem_we), 0);
    rst_n = 1'b1;
    tick(5);

    // R1 + R6: counter starts at 0; page bits of a read device byte ignored
    bus_start();
    send_byte(devb(10'h200, 1'b1), k); check("R6 read dev ack", int'(k), 1);
    recv_byte(1'b0, rb); bus_stop();
    check("R1 R6 first current read at 0", int'(rb), int'(exp_mem[0]));

    // R4 byte writes, R7 random reads, from the vector table
    for (int v = 0; v < 6; v++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = VEC[v][17:8];
      d = VEC[v][7:0];
      base_we = we_count;
      bus_start();
      send_byte(devb(a, 1'b0), k); check("R4 dev ack", int'(k), 1);
      send_byte(a[7:0], k);        check("R4 word ack", int'(k), 1);
      send_byte(d, k);             check("R4 data ack", int'(k), 1);
      bus_stop();
      exp_mem[a] = d;
      check("R4 one strobe per byte", we_count - base_we, 1);
      base_we = we_count;
      point_at(a, "R7");
      recv_byte(1'b0, rb); bus_stop();
      check("R7 random read data", int'(rb), int'(d));
      check("R7 dummy write stores nothing", we_count - base_we, 0);
    end

    // R6: counter is last read address + 1
    bus_start();
    send_byte(devb(10'h0, 1'b1), k);
    recv_byte(1'b0, rb); bus_stop();
    check("R6 current read after random", int'(rb), int'(exp_mem[10'h180]));

    // R5: 18 bytes from 0x123 wrap inside page 0x120
    base_we = we_count;
    bus_start();
    send_byte(devb(10'h123, 1'b0), k);
    send_byte(8'h23, k);
    for (int i = 0; i < 18; i++) begin
      logic [AW-1:0] wa;
      wa = 10'h120 | AW'((3 + i) % 16);
      send_byte(8'(8'hC0 + i), k);
      check("R5 page data ack", int'(k), 1);
      exp_mem[wa] = 8'(8'hC0 + i);
    end
    bus_stop();
    check("R5 strobes for page write", we_count - base_we, 18);
    bus_start();
    send_byte(devb(10'h0, 1'b1), k);
    recv_byte(1'b0, rb); bus_stop();
    check("R6 current read after page write", int'(rb), int'(exp_mem[10'h125]));
    point_at(10'h120, "R8");
    for (int i = 0; i < 16; i++) begin
      recv_byte(i != 15, rb);
      check("R5 R8 page readback", int'(rb), int'(exp_mem[10'h120 + i]));
    end
    bus_stop();

    // R8 wrap to 0, R9 nack releases the line
    point_at(10'h3FE, "R8");
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, rb);
      check("R8 sequential wrap", int'(rb), int'(exp_mem[AW'(10'h3FE + i)]));
    end
    begin
      int driven;
      driven = 0;
      sda_m = 1'b1;
      for (int c = 0; c < 9 * 4 * Q; c++) begin
        if (c % (2 * Q) == 0) scl_m = ~scl_m;
        tick(1);
        if (sda_oe) driven++;
      end
      scl_m = 1'b0; tick(Q);
      check("R9 no drive after nack", driven, 0);
    end
    bus_stop();

    // R2: wrong select bit, then wrong prefix
    base_we = we_count;
    bus_start();
    send_byte({4'b1010, 1'b0, 2'b00, 1'b0}, k); check("R2 select mismatch no ack", int'(k), 0);
    send_byte(8'h10, k);                        check("R2 later byte ignored", int'(k), 0);
    send_byte(8'h77, k);                        check("R2 data ignored", int'(k), 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, 1'b1, 2'b00, 1'b0}, k); check("R2 prefix mismatch no ack", int'(k), 0);
    bus_stop();
    check("R2 no strobe on mismatch", we_count - base_we, 0);

    // R3: start in the middle of a data byte abandons it
    base_we = we_count;
    bus_start();
    send_byte(devb(10'h040, 1'b0), k);
    send_byte(8'h40, k);
    send_bits(8'hF0, 4);
    bus_start();
    send_byte(devb(10'h040, 1'b1), k); check("R3 restart dev ack", int'(k), 1);
    recv_byte(1'b0, rb); bus_stop();
    check("R3 aborted byte not stored", we_count - base_we, 0);
    check("R3 read after abort", int'(rb), int'(exp_mem[10'h040]));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule